// File: doc/BRIEF.md
# Display Interrupt Status and ID Unit

This unit collects the event strobes of a display controller's fetch channels and frame logic into two sticky status registers. It applies a mask to each event and drives one level-sensitive interrupt line. Channel 0 is the base plane. Its events live in a primary status register, and its masks sit in a primary control register. Channels 1 to 6 use a secondary status register and a secondary mask register, and both have the same bit layout.

An interrupt-ID register tells software which frame caused the interrupt. The first unmasked channel event that arrives while the line is low loads the ID register with that channel's frame ID. Any unmasked event that arrives while the line is already high leaves the ID unchanged and sets a sticky "subsequent interrupt" flag instead.

The primary control register also holds the enable bit and the disable-request bit. Dropping the enable bit by a write reports a quick disable. A frame end that sees the disable request clears the enable bit and reports that the last frame is done. Software reaches all registers through a simple address, write-enable and read-data port. Status bits are cleared by writing 1s to them.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset the control, mask, both status and the ID registers read 0 and `irq` is low.
- R2: Primary status bit positions are as follows. Bit 0 is last-frame-done and bit 1 is channel-0 start of frame. Bit 2 is bus error, with the channel number of the lowest erroring channel in bits 30:28. Bit 3 is AC-bias count. Bit 4 is channel-0 underrun and bit 5 is channel-1 underrun. Bit 6 is output underrun and bit 7 is quick disable. Bit 8 is channel-0 end of frame and bit 9 is channel-0 branch. Bit 10 is subsequent interrupt, bit 11 is read status and bit 12 is command done.
- R3: For channel c from 1 to 6, secondary status bits are as follows. Start of frame is bit c-1, end of frame is bit c+7, branch is bit c+15 and underrun is bit c+23.
- R4: A start-of-frame or end-of-frame strobe is recorded only when that channel's descriptor enable input for the event is 1.
- R5: `irq` is the OR of every set status bit that is not masked. The channel-0 masks sit in control bits 3 (last-frame-done), 4 (SOF), 5 (underrun 0), 6 (EOF), 11 (quick disable), 20 (branch), 21 (output underrun), 23 (read status) and 24 (command). Underrun 1 is masked by secondary mask bit 24. Secondary status is masked bit for bit by the secondary mask register. A 1 masks the event. Bus error cannot be masked. AC-bias and subsequent-interrupt never drive `irq`.
- R6: An unmasked SOF, EOF or branch event, or any bus error, is handled in one of two ways. If `irq` is low in that cycle, the ID register loads the frame ID of the lowest-numbered channel with such an event. If `irq` is high, primary bit 10 is set and the ID register is unchanged.
- R7: A masked event sets its status bit but changes neither the ID register nor bit 10.
- R8: Writing the primary status register clears every bit among 11:0 that is written 1. Writing 1 to bit 2 also clears bits 30:28. Bit 12 is not cleared by such a write. A write to the secondary status register clears only the written-1 bits within 0x003E3F3F.
- R9: An event recorded in the same cycle as a write that clears its bit leaves the bit set.
- R10: The control register keeps bits 26:0 of a write. A write that changes bit 0 (enable) from 1 to 0 sets quick disable (bit 7).
- R11: A `frame_done` strobe while control bit 10 is 1 clears the enable bit and sets last-frame-done. With bit 10 at 0 the strobe changes nothing.
- R12: Writes to the ID register are ignored. The secondary mask register keeps only bits in 0x3F3F3F3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_pulse | input | NCH | Start-of-frame strobe per channel |
| eof_pulse | input | NCH | End-of-frame strobe per channel |
| br_pulse | input | NCH | Branch-taken strobe per channel |
| berr_pulse | input | NCH | Bus-error strobe per channel |
| iu_pulse | input | NCH | Input-underrun strobe per channel |
| sof_en | input | NCH | Descriptor enables start-of-frame reporting |
| eof_en | input | NCH | Descriptor enables end-of-frame reporting |
| frame_id | input | NCH*32 | Current frame ID per channel, channel 0 in the low word |
| acb_pulse | input | 1 | AC-bias count event |
| ou_pulse | input | 1 | Output underrun event |
| rdst_pulse | input | 1 | Panel read-status event |
| cmd_pulse | input | 1 | Command-done event |
| frame_done | input | 1 | Frame end strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | Current enable bit |

## Verification
Some invariants are checked by assertions on every cycle. The ID register holds still while `irq` is high. The subsequent flag can only rise after a cycle with `irq` high. A set bus-error bit always raises `irq`, and the bus-error channel field is zero whenever its flag is clear. The enable bit never falls without quick disable or last-frame-done being reported, and last-frame-done only rises after a disable request. The bench scenarios show what no single-cycle property can: exact bit positions per channel, which channel wins a same-cycle ID contest, the clear masks of both status registers, and set-over-clear races.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
    localparam int DATA_W = 32;

    // primary status positions
    localparam int S0_LDD  = 0;
    localparam int S0_SOF  = 1;
    localparam int S0_BER  = 2;
    localparam int S0_ACB  = 3;
    localparam int S0_IU0  = 4;
    localparam int S0_IU1  = 5;
    localparam int S0_OU   = 6;
    localparam int S0_QD   = 7;
    localparam int S0_EOF  = 8;
    localparam int S0_BR   = 9;
    localparam int S0_SUB  = 10;
    localparam int S0_RDST = 11;
    localparam int S0_CMD  = 12;
    localparam int S0_CH_LO = 28;

    // primary control positions
    localparam int C0_EN     = 0;
    localparam int C0_M_LDD  = 3;
    localparam int C0_M_SOF  = 4;
    localparam int C0_M_IU   = 5;
    localparam int C0_M_EOF  = 6;
    localparam int C0_DISREQ = 10;
    localparam int C0_M_QD   = 11;
    localparam int C0_M_BR   = 20;
    localparam int C0_M_OU   = 21;
    localparam int C0_M_RDST = 23;
    localparam int C0_M_CMD  = 24;

    localparam logic [DATA_W-1:0] C0_KEEP  = 32'h07FF_FFFF;
    localparam logic [DATA_W-1:0] M1_KEEP  = 32'h3F3F_3F3F;
    localparam logic [DATA_W-1:0] S0_CLRMK = 32'h0000_0FFF;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl0;
        logic [DATA_W-1:0] mask1;
        logic [DATA_W-1:0] stat0;
        logic [DATA_W-1:0] stat1;
        logic [DATA_W-1:0] id;
    } regs_t;
endpackage

// File: rtl/disp_irq_events.sv
module disp_irq_events
    import disp_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic [NCH-1:0]        sof_pulse,
    input  logic [NCH-1:0]        eof_pulse,
    input  logic [NCH-1:0]        br_pulse,
    input  logic [NCH-1:0]        berr_pulse,
    input  logic [NCH-1:0]        iu_pulse,
    input  logic [NCH-1:0]        sof_en,
    input  logic [NCH-1:0]        eof_en,
    input  logic [NCH*DATA_W-1:0] frame_id,
    input  logic [DATA_W-1:0]     ctrl0,
    input  logic [DATA_W-1:0]     mask1,
    input  logic                  irq_now,
    output logic [DATA_W-1:0]     set0,
    output logic [DATA_W-1:0]     set1,
    output logic                  berr_any,
    output logic [2:0]            berr_chan,
    output logic                  id_load,
    output logic [DATA_W-1:0]     id_val
);
    localparam int CH_W = 3;

    logic [NCH-1:0] sof_hit, eof_hit, sof_um, eof_um, br_um, req;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign sof_hit[c] = sof_pulse[c] & sof_en[c];
        assign eof_hit[c] = eof_pulse[c] & eof_en[c];
        if (c == 0) begin : g_base
            assign sof_um[c] = ~ctrl0[C0_M_SOF];
            assign eof_um[c] = ~ctrl0[C0_M_EOF];
            assign br_um[c]  = ~ctrl0[C0_M_BR];
        end else begin : g_ovl
            assign sof_um[c] = ~mask1[c-1];
            assign eof_um[c] = ~mask1[c+7];
            assign br_um[c]  = ~mask1[c+15];
        end
        assign req[c] = (sof_hit[c] & sof_um[c]) | (eof_hit[c] & eof_um[c])
                      | (br_pulse[c] & br_um[c]) | berr_pulse[c];
    end

    always_comb begin
        set0      = '0;
        set1      = '0;
        berr_chan = '0;
        id_val    = '0;
        set0[S0_SOF] = sof_hit[0];
        set0[S0_EOF] = eof_hit[0];
        set0[S0_BR]  = br_pulse[0];
        set0[S0_IU0] = iu_pulse[0];
        if (NCH > 1) set0[S0_IU1] = iu_pulse[1];
        for (int c = 1; c < NCH; c++) begin
            set1[c-1]  = sof_hit[c];
            set1[c+7]  = eof_hit[c];
            set1[c+15] = br_pulse[c];
            set1[c+23] = iu_pulse[c];
        end
        berr_any = |berr_pulse;
        set0[S0_BER] = berr_any;
        // descending scan: lowest index wins
        for (int c = NCH-1; c >= 0; c--) begin
            if (berr_pulse[c]) berr_chan = CH_W'(c);
            if (req[c])        id_val    = frame_id[c*DATA_W +: DATA_W];
        end
        id_load      = (|req) & ~irq_now;
        set0[S0_SUB] = (|req) & irq_now;
    end
endmodule

// File: rtl/disp_irq_level.sv
module disp_irq_level
    import disp_irq_pkg::*;
(
    input  logic [DATA_W-1:0] stat0,
    input  logic [DATA_W-1:0] stat1,
    input  logic [DATA_W-1:0] ctrl0,
    input  logic [DATA_W-1:0] mask1,
    output logic              irq
);
    logic [DATA_W-1:0] en0;

    always_comb begin
        en0           = '0;
        en0[S0_LDD]   = ~ctrl0[C0_M_LDD];
        en0[S0_SOF]   = ~ctrl0[C0_M_SOF];
        en0[S0_BER]   = 1'b1;
        en0[S0_IU0]   = ~ctrl0[C0_M_IU];
        en0[S0_IU1]   = ~mask1[24];
        en0[S0_OU]    = ~ctrl0[C0_M_OU];
        en0[S0_QD]    = ~ctrl0[C0_M_QD];
        en0[S0_EOF]   = ~ctrl0[C0_M_EOF];
        en0[S0_BR]    = ~ctrl0[C0_M_BR];
        en0[S0_RDST]  = ~ctrl0[C0_M_RDST];
        en0[S0_CMD]   = ~ctrl0[C0_M_CMD];
        irq = (|(stat0 & en0)) | (|(stat1 & ~mask1));
    end
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
    import disp_irq_pkg::*;
#(
    parameter int                NCH       = 7,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFF_CTRL0 = 8'h00,
    parameter logic [ADDR_W-1:0] OFF_MASK1 = 8'h14,
    parameter logic [ADDR_W-1:0] OFF_STAT1 = 8'h34,
    parameter logic [ADDR_W-1:0] OFF_STAT0 = 8'h38,
    parameter logic [ADDR_W-1:0] OFF_ID    = 8'h3C,
    parameter logic [31:0]       CLR1_MASK = 32'h003E_3F3F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        sof_pulse,
    input  logic [NCH-1:0]        eof_pulse,
    input  logic [NCH-1:0]        br_pulse,
    input  logic [NCH-1:0]        berr_pulse,
    input  logic [NCH-1:0]        iu_pulse,
    input  logic [NCH-1:0]        sof_en,
    input  logic [NCH-1:0]        eof_en,
    input  logic [NCH*32-1:0]     frame_id,
    input  logic                  acb_pulse,
    input  logic                  ou_pulse,
    input  logic                  rdst_pulse,
    input  logic                  cmd_pulse,
    input  logic                  frame_done,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    output logic                  irq,
    output logic                  lcd_en
);
    localparam int MAX_CH = 7;
    if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
        initial $error("NCH must be between 1 and 7");
    end

    regs_t cur_q, nxt_d;

    logic [DATA_W-1:0] set0, set1, id_val;
    logic              berr_any, id_load;
    logic [2:0]        berr_chan;

    disp_irq_events #(.NCH(NCH)) u_events (
        .sof_pulse (sof_pulse),
        .eof_pulse (eof_pulse),
        .br_pulse  (br_pulse),
        .berr_pulse(berr_pulse),
        .iu_pulse  (iu_pulse),
        .sof_en    (sof_en),
        .eof_en    (eof_en),
        .frame_id  (frame_id),
        .ctrl0     (cur_q.ctrl0),
        .mask1     (cur_q.mask1),
        .irq_now   (irq),
        .set0      (set0),
        .set1      (set1),
        .berr_any  (berr_any),
        .berr_chan (berr_chan),
        .id_load   (id_load),
        .id_val    (id_val)
    );

    disp_irq_level u_level (
        .stat0(cur_q.stat0),
        .stat1(cur_q.stat1),
        .ctrl0(cur_q.ctrl0),
        .mask1(cur_q.mask1),
        .irq  (irq)
    );

    logic              wr_c0, wr_m1, wr_s0, wr_s1;
    logic [DATA_W-1:0] clr0, clr1, misc0;

    always_comb begin
        nxt_d = cur_q;
        wr_c0 = wr_en && (addr == OFF_CTRL0);
        wr_m1 = wr_en && (addr == OFF_MASK1);
        wr_s0 = wr_en && (addr == OFF_STAT0);
        wr_s1 = wr_en && (addr == OFF_STAT1);

        misc0          = '0;
        misc0[S0_ACB]  = acb_pulse;
        misc0[S0_OU]   = ou_pulse;
        misc0[S0_RDST] = rdst_pulse;
        misc0[S0_CMD]  = cmd_pulse;

        if (wr_c0) begin
            nxt_d.ctrl0 = wr_data & C0_KEEP;
            if (cur_q.ctrl0[C0_EN] && !wr_data[C0_EN]) misc0[S0_QD] = 1'b1;
        end
        if (frame_done && cur_q.ctrl0[C0_DISREQ]) begin
            nxt_d.ctrl0[C0_EN] = 1'b0;
            misc0[S0_LDD]      = 1'b1;
        end
        if (wr_m1) nxt_d.mask1 = wr_data & M1_KEEP;

        clr0 = wr_s0 ? (wr_data & S0_CLRMK) : '0;
        clr1 = wr_s1 ? (wr_data & CLR1_MASK) : '0;

        nxt_d.stat0 = (cur_q.stat0 & ~clr0) | set0 | misc0;
        if (berr_any)
            nxt_d.stat0[S0_CH_LO +: 3] = berr_chan;
        else if (wr_s0 && wr_data[S0_BER])
            nxt_d.stat0[S0_CH_LO +: 3] = 3'd0;

        nxt_d.stat1 = (cur_q.stat1 & ~clr1) | set1;

        if (id_load) nxt_d.id = id_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        rd_data = '0;
        if      (addr == OFF_CTRL0) rd_data = cur_q.ctrl0;
        else if (addr == OFF_MASK1) rd_data = cur_q.mask1;
        else if (addr == OFF_STAT0) rd_data = cur_q.stat0;
        else if (addr == OFF_STAT1) rd_data = cur_q.stat1;
        else if (addr == OFF_ID)    rd_data = cur_q.id;
    end

    assign lcd_en = cur_q.ctrl0[C0_EN];
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [31:0] stat0,
    input logic [31:0] ctrl0,
    input logic [31:0] id
);
    // R6: ID register frozen while the line is high
    a_r6_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> $stable(id));

    // R6: subsequent flag rises only after a cycle with the line high
    a_r6_sub_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat0[10]) |-> $past(irq));

    // R5: a recorded bus error always raises the line
    a_r5_berr_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        stat0[2] |-> irq);

    // R8: channel field is zero whenever the bus-error flag is clear
    a_r8_berr_field: assert property (@(posedge clk) disable iff (!rst_n)
        !stat0[2] |-> (stat0[30:28] == 3'd0));

    // R10: enable drops only with quick disable or last-frame-done reported
    a_r10_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl0[0]) |-> (stat0[7] || stat0[0]));

    // R11: last-frame-done rises only after a disable request
    a_r11_ldd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat0[0]) |-> $past(ctrl0[10]));
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .irq  (irq),
    .stat0(cur_q.stat0),
    .ctrl0(cur_q.ctrl0),
    .id   (cur_q.id)
);

// File: tb/disp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module disp_irq_ctrl_tb;
    localparam int NCH = 7;
    localparam logic [7:0] A_C0 = 8'h00, A_M1 = 8'h14, A_S1 = 8'h34,
                           A_S0 = 8'h38, A_ID = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] sof_pulse = '0, eof_pulse = '0, br_pulse = '0,
                    berr_pulse = '0, iu_pulse = '0, sof_en = '0, eof_en = '0;
    logic [NCH*32-1:0] frame_id;
    logic acb_pulse = 0, ou_pulse = 0, rdst_pulse = 0, cmd_pulse = 0;
    logic frame_done = 0, wr_en = 0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic irq, lcd_en;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    for (genvar c = 0; c < NCH; c++) begin : g_id
        assign frame_id[c*32 +: 32] = 32'hA000_0000 + 32'(c * 17);
    end

    function automatic logic [31:0] fid(int c);
        return 32'hA000_0000 + 32'(c * 17);
    endfunction

    disp_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .sof_pulse(sof_pulse), .eof_pulse(eof_pulse), .br_pulse(br_pulse),
        .berr_pulse(berr_pulse), .iu_pulse(iu_pulse),
        .sof_en(sof_en), .eof_en(eof_en), .frame_id(frame_id),
        .acb_pulse(acb_pulse), .ou_pulse(ou_pulse), .rdst_pulse(rdst_pulse),
        .cmd_pulse(cmd_pulse), .frame_done(frame_done),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .lcd_en(lcd_en)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        sof_en = '0; eof_en = '0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse(logic [NCH-1:0] s, logic [NCH-1:0] e,
                         logic [NCH-1:0] b, logic [NCH-1:0] be,
                         logic [NCH-1:0] iu);
        sof_pulse = s; eof_pulse = e; br_pulse = b; berr_pulse = be; iu_pulse = iu;
        @(negedge clk);
        sof_pulse = '0; eof_pulse = '0; br_pulse = '0; berr_pulse = '0; iu_pulse = '0;
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1 ctrl0", A_C0, 0);
        rd_chk("R1 mask1", A_M1, 0);
        rd_chk("R1 stat0", A_S0, 0);
        rd_chk("R1 stat1", A_S1, 0);
        rd_chk("R1 id", A_ID, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_sof_ch0();
        do_reset();
        pulse(7'h01, 0, 0, 0, 0);
        rd_chk("R4 sof without enable", A_S0, 0);
        check("R4 irq", 32'(irq), 0);
        sof_en = 7'h01;
        pulse(7'h01, 0, 0, 0, 0);
        rd_chk("R2 sof ch0 bit1", A_S0, 32'h2);
        check("R5 irq on sof", 32'(irq), 1);
        rd_chk("R6 id ch0", A_ID, fid(0));
        wr(A_S0, 32'h2);
        rd_chk("R8 clear sof", A_S0, 0);
        check("R5 irq after clear", 32'(irq), 0);
    endtask

    task automatic t_overlay();
        do_reset();
        eof_en = 7'h08;
        pulse(0, 7'h08, 0, 0, 0);
        rd_chk("R3 eof ch3 bit10", A_S1, 32'h400);
        rd_chk("R6 id ch3", A_ID, fid(3));
        check("R5 irq stat1", 32'(irq), 1);
        pulse(0, 0, 7'h20, 0, 0);
        rd_chk("R3 branch ch5 bit20", A_S1, 32'h0010_0400);
        rd_chk("R6 subsequent flag", A_S0, 32'h400);
        rd_chk("R6 id kept", A_ID, fid(3));
    endtask

    task automatic t_masked();
        do_reset();
        wr(A_C0, 32'h10);
        wr(A_M1, 32'h2);
        sof_en = 7'h05;
        pulse(7'h05, 0, 0, 0, 0);
        rd_chk("R7 stat0 set", A_S0, 32'h2);
        rd_chk("R7 stat1 set", A_S1, 32'h2);
        check("R5 masked irq low", 32'(irq), 0);
        rd_chk("R7 id untouched", A_ID, 0);
    endtask

    task automatic t_berr();
        do_reset();
        wr(A_C0, 32'h07FF_FBFE);
        wr(A_M1, 32'hFFFF_FFFF);
        pulse(0, 0, 0, 7'h50, 0);
        rd_chk("R2 berr field lowest ch4", A_S0, 32'h4000_0004);
        check("R5 berr unmaskable", 32'(irq), 1);
        rd_chk("R6 berr id", A_ID, fid(4));
        wr(A_S0, 32'h4);
        rd_chk("R8 berr clear field", A_S0, 0);
        check("R8 irq after berr clear", 32'(irq), 0);
    endtask

    task automatic t_simul();
        do_reset();
        eof_en = 7'h44;
        pulse(0, 7'h44, 0, 0, 0);
        rd_chk("R6 lowest channel id", A_ID, fid(2));
        rd_chk("R3 eof ch2 ch6", A_S1, 32'h0000_2200);
        rd_chk("R6 no sub flag", A_S0, 0);
    endtask

    task automatic t_race();
        do_reset();
        sof_en = 7'h03;
        pulse(7'h03, 0, 0, 0, 0);
        addr = A_S0; wr_data = 32'h2; wr_en = 1; sof_pulse = 7'h01;
        @(negedge clk);
        wr_en = 0; sof_pulse = '0;
        rd_chk("R9 stat0 set beats clear", A_S0, 32'h402);
        addr = A_S1; wr_data = 32'h1; wr_en = 1; sof_pulse = 7'h02;
        @(negedge clk);
        wr_en = 0; sof_pulse = '0;
        rd_chk("R9 stat1 set beats clear", A_S1, 32'h1);
    endtask

    task automatic t_ctrl0();
        do_reset();
        wr(A_C0, 32'hFFFF_FFFF);
        rd_chk("R10 ctrl0 keeps 26:0", A_C0, 32'h07FF_FFFF);
        check("R10 lcd_en", 32'(lcd_en), 1);
        rd_chk("R10 no qd yet", A_S0, 0);
        wr(A_C0, 32'h0);
        rd_chk("R10 quick disable", A_S0, 32'h80);
        check("R5 qd irq", 32'(irq), 1);
    endtask

    task automatic t_done();
        do_reset();
        wr(A_C0, 32'h1);
        frame_done = 1; @(negedge clk); frame_done = 0;
        rd_chk("R11 no request", A_C0, 32'h1);
        rd_chk("R11 no ldd", A_S0, 0);
        wr(A_C0, 32'h401);
        frame_done = 1; @(negedge clk); frame_done = 0;
        rd_chk("R11 enable cleared", A_C0, 32'h400);
        rd_chk("R11 ldd set", A_S0, 32'h1);
    endtask

    task automatic t_misc();
        do_reset();
        acb_pulse = 1; @(negedge clk); acb_pulse = 0;
        rd_chk("R2 acb bit3", A_S0, 32'h8);
        check("R5 acb no irq", 32'(irq), 0);
        ou_pulse = 1; rdst_pulse = 1; cmd_pulse = 1;
        iu_pulse = 7'h01;
        @(negedge clk);
        ou_pulse = 0; rdst_pulse = 0; cmd_pulse = 0; iu_pulse = '0;
        rd_chk("R2 misc bits", A_S0, 32'h1858);
        wr(A_S0, 32'hFFFF_FFFF);
        rd_chk("R8 bit12 survives", A_S0, 32'h1000);
        check("R8 cmd irq stays", 32'(irq), 1);
    endtask

    task automatic t_regs();
        do_reset();
        wr(A_ID, 32'hDEAD_BEEF);
        rd_chk("R12 id write ignored", A_ID, 0);
        wr(A_M1, 32'hFFFF_FFFF);
        rd_chk("R12 mask1 keep", A_M1, 32'h3F3F_3F3F);
        sof_en = 7'h02;
        pulse(7'h02, 0, 7'h02, 0, 7'h02);
        rd_chk("R3 ch1 sof br iu", A_S1, 32'h0101_0001);
        rd_chk("R2 iu1 in stat0", A_S0, 32'h20);
        wr(A_S1, 32'hFFFF_FFFF);
        rd_chk("R8 stat1 clear mask", A_S1, 32'h0101_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_sof_ch0();
        t_overlay();
        t_masked();
        t_berr();
        t_simul();
        t_race();
        t_ctrl0();
        t_done();
        t_misc();
        t_regs();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule